// File: doc/BRIEF.md
# Dual-Slot Card Clock Generator

This block derives the clocks for two card slots from a single host clock. Four shared 8-bit divisors are held in an active settings bank. Each slot chooses one of them through its own selector and produces two outputs: a registered clock level, and a one-cycle enable pulse that marks the first host cycle of every card-clock high phase. Logic clocked by the host clock uses the pulse. Each slot can be switched off, and it can be put in a low-power mode that stops its clock whenever the slot reports that it is not busy.

Configuration inputs reach the active bank only on a one-cycle update strobe from the command sequencer. A slot reads its divisor only at the start of a period, and a slot stops only at the end of a low phase. The result is that no high or low phase is ever cut short. A separate base clock generator has a 4-bit period field P and a 4-bit high-time field H, which are also taken in by the update strobe.

Each slot runs a three-state machine. STOP holds the clock low. HIGH drives the high phase and raises the enable pulse in its first cycle. LOW drives the low phase. The transitions are:
- start (STOP to HIGH, when the slot may run);
- end-of-high (HIGH to LOW, after N cycles);
- restart (LOW to HIGH, when the slot may still run at the end of the low phase);
- park (LOW to STOP, when it may not);
- bypass-stop (HIGH to STOP, with divisor 0, when it may not run);
- bypass-repeat (HIGH to HIGH, with divisor 0).

Top module: `card_clk_gen`

## Requirements
- R1: While reset is held, and right after it, both slot clocks and both enable pulses are 0 and the base clock is 1, because all active settings are 0.
- R2: Changes on the divisor, select, enable, low-power, period and high-time inputs have no effect on any output unless update_i is 1 on a clock edge; on that edge all of them are copied into the active bank together.
- R3: With a divisor N from 1 to 255, a slot's clock is high for N host cycles and then low for N host cycles, a period of 2N, and card_ce_o is 1 only in the first high cycle.
- R4: With divisor 0 (bypass), a running slot holds card_clk_o at 1 and pulses card_ce_o in every host cycle.
- R5: Slot s uses the divisor whose index k is given by slot_sel_i[2s+1:2s]; divisor k is div_val_i[8k+7:8k].
- R6: When a slot's enable bit (slot_en_i[s]) is 0, its clock parks low at the end of the current low phase, or at once in bypass, and stays low while the bit remains 0.
- R7: When the low-power bit (slot_lp_i[s]) is 1 and slot_busy_i[s] is 0, the slot parks as in R6; it restarts with a full high phase once busy returns to 1.
- R8: A slot reads its divisor only at the start of a high phase, so an update in the middle of a period never shortens or stretches the current high or low phase.
- R9: With H < P, the base clock repeats a pattern of H+1 high cycles followed by P-H low cycles, a period of P+1.
- R10: With H >= P, the base clock stays at 1.
- R11: New P and H values are used only from the first cycle of the next base period.
- R12: A slot leaving STOP begins with its full high phase, and its enable pulse rises in the same cycle as its clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_val_i | input | 32 | Four 8-bit divisor values; divisor k is at bits [8k+7:8k] |
| slot_sel_i | input | 4 | Divisor select for each slot, 2 bits per slot |
| slot_en_i | input | 2 | Clock enable for each slot |
| slot_lp_i | input | 2 | Low-power (idle stop) bit for each slot |
| slot_busy_i | input | 2 | Live busy indication for each slot, not latched |
| update_i | input | 1 | Update strobe that loads all settings into the active bank |
| base_period_i | input | 4 | Base period field P |
| base_high_i | input | 4 | Base high-time field H |
| card_clk_o | output | 2 | Registered card clock level for each slot |
| card_ce_o | output | 2 | One-cycle pulse for each slot at the start of every high phase |
| base_clk_o | output | 1 | Base generator clock output |

## Verification
The hard case is an update strobe that arrives in the same cycle as a slot's period boundary (restart) or a base period wrap. In that cycle the boundary must still use the old active values, and the new values must first appear in the period that follows. The bench provokes this in two ways. Directed phases place strobes next to high and low phases of known length. A long random phase issues strobes at every possible offset, with random divisors, selects and busy patterns. Every output is judged cycle by cycle against a behavioural model that counts the cycles left in each phase.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
    // Per-slot clock state
    typedef enum logic [1:0] {
        SLOT_STOP = 2'd0,
        SLOT_HIGH = 2'd1,
        SLOT_LOW  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/ccg_shadow.sv
module ccg_shadow #(
    parameter int NUM_SLOTS = 2,
    parameter int NUM_DIVS  = 4,
    parameter int DIV_W     = 8,
    parameter int BASE_W    = 4,
    localparam int SEL_W    = $clog2(NUM_DIVS),
    localparam int DIVS_W   = NUM_DIVS * DIV_W,
    localparam int SELS_W   = NUM_SLOTS * SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 update_i,
    input  logic [DIVS_W-1:0]    div_i,
    input  logic [SELS_W-1:0]    sel_i,
    input  logic [NUM_SLOTS-1:0] en_i,
    input  logic [NUM_SLOTS-1:0] lp_i,
    input  logic [BASE_W-1:0]    per_i,
    input  logic [BASE_W-1:0]    hi_i,
    output logic [DIVS_W-1:0]    div_o,
    output logic [SELS_W-1:0]    sel_o,
    output logic [NUM_SLOTS-1:0] en_o,
    output logic [NUM_SLOTS-1:0] lp_o,
    output logic [BASE_W-1:0]    per_o,
    output logic [BASE_W-1:0]    hi_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_o <= '0;
            sel_o <= '0;
            en_o  <= '0;
            lp_o  <= '0;
            per_o <= '0;
            hi_o  <= '0;
        end else if (update_i) begin
            div_o <= div_i;
            sel_o <= sel_i;
            en_o  <= en_i;
            lp_o  <= lp_i;
            per_o <= per_i;
            hi_o  <= hi_i;
        end
    end

    AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !update_i |=> ($stable(div_o) && $stable(sel_o) && $stable(en_o) &&
                       $stable(lp_o) && $stable(per_o) && $stable(hi_o))); // R2

endmodule

// File: rtl/ccg_slot.sv
module ccg_slot
    import ccg_pkg::*;
#(
    parameter int NUM_DIVS = 4,
    parameter int DIV_W    = 8,
    localparam int SEL_W   = $clog2(NUM_DIVS),
    localparam int DIVS_W  = NUM_DIVS * DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIVS_W-1:0] div_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              en_i,
    input  logic              lp_i,
    input  logic              busy_i,
    output logic              card_clk_o,
    output logic              card_ce_o
);

    slot_state_e      state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] curn_q, curn_d;
    logic [DIV_W-1:0] sel_n;
    logic             run;
    logic             last_cyc;

    always_comb begin
        sel_n    = div_i[32'(sel_i) * DIV_W +: DIV_W];
        run      = en_i & ~(lp_i & ~busy_i);
        last_cyc = (cnt_q == curn_q - DIV_W'(1));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        curn_d  = curn_q;
        unique case (state_q)
            SLOT_STOP: begin
                if (run) begin            // start
                    state_d = SLOT_HIGH;
                    cnt_d   = '0;
                    curn_d  = sel_n;
                end
            end
            SLOT_HIGH: begin
                if (curn_q == '0) begin
                    if (!run) begin       // bypass-stop
                        state_d = SLOT_STOP;
                        cnt_d   = '0;
                    end else begin        // bypass-repeat
                        cnt_d   = '0;
                        curn_d  = sel_n;
                    end
                end else if (last_cyc) begin  // end-of-high
                    state_d = SLOT_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + DIV_W'(1);
                end
            end
            SLOT_LOW: begin
                if (last_cyc) begin
                    cnt_d = '0;
                    if (run) begin        // restart
                        state_d = SLOT_HIGH;
                        curn_d  = sel_n;
                    end else begin        // park
                        state_d = SLOT_STOP;
                    end
                end else begin
                    cnt_d = cnt_q + DIV_W'(1);
                end
            end
            default: begin
                state_d = SLOT_STOP;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_STOP;
            cnt_q   <= '0;
            curn_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            curn_q  <= curn_d;
        end
    end

    // Outputs
    always_comb begin
        card_clk_o = (state_q == SLOT_HIGH);
        card_ce_o  = (state_q == SLOT_HIGH) && (cnt_q == '0);
    end

    AST_RISE_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk_o) |-> card_ce_o); // R12

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(card_clk_o) && $past(curn_q) != '0) |->
            ($past(cnt_q) == $past(curn_q) - DIV_W'(1))); // R8

    AST_PARK_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_STOP && $past(state_q) != SLOT_STOP) |->
            ($past(state_q) == SLOT_LOW || $past(curn_q) == '0)); // R6

    AST_OFF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_STOP && !en_i) |=> (state_q == SLOT_STOP)); // R6

endmodule

// File: rtl/ccg_base_gen.sv
module ccg_base_gen #(
    parameter int BASE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] per_i,
    input  logic [BASE_W-1:0] hi_i,
    output logic              base_clk_o
);

    logic [BASE_W-1:0] bcnt_q;
    logic [BASE_W-1:0] bp_q;
    logic [BASE_W-1:0] bh_q;
    logic              wrap;

    always_comb wrap = (bcnt_q >= bp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q <= '0;
            bp_q   <= '0;
            bh_q   <= '0;
        end else if (wrap) begin
            bcnt_q <= '0;
            bp_q   <= per_i;
            bh_q   <= hi_i;
        end else begin
            bcnt_q <= bcnt_q + BASE_W'(1);
        end
    end

    always_comb base_clk_o = (bcnt_q <= bh_q);

    AST_BASE_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(base_clk_o) |-> (bcnt_q == '0)); // R9

    AST_BASE_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bcnt_q) < $past(bp_q)) |-> ($stable(bp_q) && $stable(bh_q))); // R11

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
    parameter int NUM_SLOTS = 2,
    parameter int NUM_DIVS  = 4,
    parameter int DIV_W     = 8,
    parameter int BASE_W    = 4,
    localparam int SEL_W    = $clog2(NUM_DIVS),
    localparam int DIVS_W   = NUM_DIVS * DIV_W,
    localparam int SELS_W   = NUM_SLOTS * SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIVS_W-1:0]    div_val_i,
    input  logic [SELS_W-1:0]    slot_sel_i,
    input  logic [NUM_SLOTS-1:0] slot_en_i,
    input  logic [NUM_SLOTS-1:0] slot_lp_i,
    input  logic [NUM_SLOTS-1:0] slot_busy_i,
    input  logic                 update_i,
    input  logic [BASE_W-1:0]    base_period_i,
    input  logic [BASE_W-1:0]    base_high_i,
    output logic [NUM_SLOTS-1:0] card_clk_o,
    output logic [NUM_SLOTS-1:0] card_ce_o,
    output logic                 base_clk_o
);

    logic [DIVS_W-1:0]    act_div;
    logic [SELS_W-1:0]    act_sel;
    logic [NUM_SLOTS-1:0] act_en;
    logic [NUM_SLOTS-1:0] act_lp;
    logic [BASE_W-1:0]    act_per;
    logic [BASE_W-1:0]    act_hi;

    ccg_shadow #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_DIVS  (NUM_DIVS),
        .DIV_W     (DIV_W),
        .BASE_W    (BASE_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .update_i (update_i),
        .div_i    (div_val_i),
        .sel_i    (slot_sel_i),
        .en_i     (slot_en_i),
        .lp_i     (slot_lp_i),
        .per_i    (base_period_i),
        .hi_i     (base_high_i),
        .div_o    (act_div),
        .sel_o    (act_sel),
        .en_o     (act_en),
        .lp_o     (act_lp),
        .per_o    (act_per),
        .hi_o     (act_hi)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        ccg_slot #(
            .NUM_DIVS (NUM_DIVS),
            .DIV_W    (DIV_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .div_i      (act_div),
            .sel_i      (act_sel[s*SEL_W +: SEL_W]),
            .en_i       (act_en[s]),
            .lp_i       (act_lp[s]),
            .busy_i     (slot_busy_i[s]),
            .card_clk_o (card_clk_o[s]),
            .card_ce_o  (card_ce_o[s])
        );
    end

    ccg_base_gen #(
        .BASE_W (BASE_W)
    ) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_i      (act_per),
        .hi_i       (act_hi),
        .base_clk_o (base_clk_o)
    );

endmodule

// File: tb/tb_card_clk_gen.sv
module tb_card_clk_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] div_val = '0;
    logic [3:0]  slot_sel = '0;
    logic [1:0]  slot_en = '0;
    logic [1:0]  slot_lp = '0;
    logic [1:0]  slot_busy = '0;
    logic        update = 1'b0;
    logic [3:0]  base_per = '0;
    logic [3:0]  base_hi = '0;
    logic [1:0]  card_clk;
    logic [1:0]  card_ce;
    logic        base_clk;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit done = 0;

    always #5 clk = ~clk;

    card_clk_gen dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_val_i     (div_val),
        .slot_sel_i    (slot_sel),
        .slot_en_i     (slot_en),
        .slot_lp_i     (slot_lp),
        .slot_busy_i   (slot_busy),
        .update_i      (update),
        .base_period_i (base_per),
        .base_high_i   (base_hi),
        .card_clk_o    (card_clk),
        .card_ce_o     (card_ce),
        .base_clk_o    (base_clk)
    );

    // Behavioural reference: cycles left in the current phase
    int a_div[4];
    int a_sel[2];
    int a_en[2];
    int a_lp[2];
    int a_p, a_h;
    int m_on[2], m_lvl[2], m_rem[2], m_n[2], m_ce[2];
    int b_cnt, b_p, b_h;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) a_div[k] = 0;
            for (int s = 0; s < 2; s++) begin
                a_sel[s] = 0; a_en[s] = 0; a_lp[s] = 0;
                m_on[s] = 0; m_lvl[s] = 0; m_rem[s] = 0; m_n[s] = 0; m_ce[s] = 0;
            end
            a_p = 0; a_h = 0; b_cnt = 0; b_p = 0; b_h = 0;
        end else begin
            for (int s = 0; s < 2; s++) begin
                int run;
                int pick;
                run  = (a_en[s] != 0 && !(a_lp[s] != 0 && slot_busy[s] == 1'b0)) ? 1 : 0;
                pick = a_div[a_sel[s]];
                m_ce[s] = 0;
                if (m_on[s] == 0) begin
                    if (run != 0) begin
                        m_on[s] = 1; m_lvl[s] = 1; m_n[s] = pick;
                        m_rem[s] = (pick == 0) ? 1 : pick; m_ce[s] = 1;
                    end
                end else if (m_lvl[s] != 0) begin
                    if (m_n[s] == 0) begin
                        if (run == 0) begin
                            m_on[s] = 0; m_lvl[s] = 0;
                        end else begin
                            m_n[s] = pick; m_rem[s] = (pick == 0) ? 1 : pick; m_ce[s] = 1;
                        end
                    end else begin
                        m_rem[s]--;
                        if (m_rem[s] == 0) begin
                            m_lvl[s] = 0; m_rem[s] = m_n[s];
                        end
                    end
                end else begin
                    m_rem[s]--;
                    if (m_rem[s] == 0) begin
                        if (run != 0) begin
                            m_lvl[s] = 1; m_n[s] = pick;
                            m_rem[s] = (pick == 0) ? 1 : pick; m_ce[s] = 1;
                        end else begin
                            m_on[s] = 0;
                        end
                    end
                end
            end
            if (b_cnt >= b_p) begin
                b_cnt = 0; b_p = a_p; b_h = a_h;
            end else begin
                b_cnt++;
            end
            if (update) begin
                for (int k = 0; k < 4; k++) a_div[k] = int'(div_val[8*k +: 8]);
                for (int s = 0; s < 2; s++) begin
                    a_sel[s] = int'(slot_sel[2*s +: 2]);
                    a_en[s]  = int'(slot_en[s]);
                    a_lp[s]  = int'(slot_lp[s]);
                end
                a_p = int'(base_per); a_h = int'(base_hi);
            end
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [1:0] e_clk, e_ce;
            logic       e_base;
            for (int s = 0; s < 2; s++) begin
                e_clk[s] = (m_on[s] != 0 && m_lvl[s] != 0);
                e_ce[s]  = (m_ce[s] != 0);
            end
            e_base = (b_cnt <= b_h);
            checks++;
            if (card_clk !== e_clk || card_ce !== e_ce || base_clk !== e_base) begin
                errors++;
                $display("FAIL %s t=%0t clk=%b/%b ce=%b/%b base=%b/%b (actual/expected)",
                         cur_req, $time, card_clk, e_clk, card_ce, e_ce, base_clk, e_base);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        update = 1'b1;
        @(negedge clk);
        update = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        cyc(3);
        checks++;
        if (card_clk !== 2'b00 || card_ce !== 2'b00 || base_clk !== 1'b1) begin
            errors++;
            $display("FAIL R1 clk=%b ce=%b base=%b expected 00 00 1", card_clk, card_ce, base_clk);
        end
        rst_n = 1'b1;
        cyc(5);

        // R3, R12: divisor 3 on slot 0, divisor 1 on slot 1
        cur_req = "R3";
        div_val = {8'd0, 8'd0, 8'd1, 8'd3};
        slot_sel = {2'd1, 2'd0};
        slot_en = 2'b11;
        slot_busy = 2'b11;
        strobe();
        cyc(40);

        // R2: inputs change without a strobe
        cur_req = "R2";
        div_val = {8'd9, 8'd9, 8'd9, 8'd9};
        slot_sel = 4'b1111;
        slot_en = 2'b00;
        base_per = 4'd7;
        base_hi = 4'd1;
        cyc(30);

        // R4: bypass on slot 1
        cur_req = "R4";
        div_val = {8'd5, 8'd0, 8'd1, 8'd3};
        slot_sel = {2'd2, 2'd0};
        slot_en = 2'b11;
        base_per = 4'd0;
        base_hi = 4'd0;
        strobe();
        cyc(20);

        // R5: slot 0 moves to divisor index 3
        cur_req = "R5";
        slot_sel = {2'd2, 2'd3};
        strobe();
        cyc(40);

        // R6: disable slot 0 mid period, and bypass slot 1
        cur_req = "R6";
        cyc(2);
        slot_en = 2'b00;
        strobe();
        cyc(30);

        // R7: low power on slot 1 with busy toggling
        cur_req = "R7";
        div_val = {8'd5, 8'd2, 8'd1, 8'd3};
        slot_sel = {2'd2, 2'd0};
        slot_en = 2'b11;
        slot_lp = 2'b10;
        strobe();
        for (int i = 0; i < 6; i++) begin
            slot_busy[1] = 1'b0;
            cyc(9 + i);
            slot_busy[1] = 1'b1;
            cyc(7 + i);
        end

        // R8: updates landing inside high and low phases
        cur_req = "R8";
        slot_lp = 2'b00;
        for (int i = 0; i < 8; i++) begin
            div_val = {8'd2, 8'd7, 8'd4, 8'(1 + 2 * i)};
            strobe();
            cyc(3 + i);
        end
        cyc(30);

        // R9: base P=5, H=2
        cur_req = "R9";
        base_per = 4'd5;
        base_hi = 4'd2;
        strobe();
        cyc(30);

        // R10: base H >= P
        cur_req = "R10";
        base_per = 4'd3;
        base_hi = 4'd7;
        strobe();
        cyc(20);

        // R11: base change in mid period
        cur_req = "R11";
        base_per = 4'd12;
        base_hi = 4'd4;
        strobe();
        cyc(5);
        base_per = 4'd6;
        base_hi = 4'd0;
        strobe();
        cyc(40);

        // R8, R12: random strobes at every offset against the model
        cur_req = "R8";
        for (int i = 0; i < 400; i++) begin
            div_val = {8'($urandom_range(0, 4)), 8'($urandom_range(0, 6)),
                       8'($urandom_range(0, 3)), 8'($urandom_range(1, 9))};
            slot_sel = 4'($urandom);
            slot_en = 2'($urandom_range(1, 3));
            slot_lp = 2'($urandom);
            slot_busy = 2'($urandom);
            base_per = 4'($urandom);
            base_hi = 4'($urandom);
            strobe();
            cyc($urandom_range(0, 12));
        end

        cur_req = "R12";
        slot_en = 2'b00;
        strobe();
        cyc(40);
        slot_en = 2'b11;
        slot_lp = 2'b00;
        strobe();
        cyc(30);

        finish_run();
    end

endmodule